// File: doc/BRIEF.md
# Reciprocal-Refining Integer Divider

This block divides one unsigned integer by another and returns either the quotient or the remainder. It does not produce one quotient bit per cycle. It normalises the divisor and takes a coarse reciprocal from a small table that is filled at elaboration. It then sharpens that reciprocal with Newton-Raphson steps of the form y = y*(2 - d*y). The dividend multiplied by the sharpened reciprocal gives a quotient estimate. The estimate is either exact or one too small, so a single remainder comparison finishes the job.

The number of refinement steps follows the size of the dividend. A small dividend can only produce a small quotient, which tolerates a coarser reciprocal. A narrow mode divides the lower halves of both operands and returns a zero-extended result. A zero divisor bypasses the arithmetic altogether.

Operands enter through a valid/ready handshake. The block accepts one operation at a time: `in_ready` is high only while the block is idle. The result is offered with `out_valid` and stays on the port until the consumer raises `out_ready`. The block takes no new operand until that handshake is complete, so back-pressure on the output stops the input side.

Top module: `recip_divider`

## Requirements
- R1: With `in_modulo` low and a nonzero divisor, `out_result` equals the floor of dividend divided by divisor, for every pair of unsigned operands, including divisor 1, divisor all-ones and power-of-two divisors.
- R2: With `in_modulo` high and a nonzero divisor, `out_result` equals dividend minus quotient times divisor, and so is strictly less than the divisor.
- R3: With `in_narrow` high, only bits [31:0] of both operands take part, and bits [63:32] of `out_result` are zero.
- R4: When the divisor, after narrow masking, is zero, `out_result` is zero and `out_valid` rises on the first clock edge after acceptance.
- R5: For a nonzero divisor, `out_valid` rises 5 + 2*N clock edges after the accepting edge. N is the refinement step count: N is 1 when the masked dividend is below 2^16, 2 when it is below 2^32, and 3 otherwise.
- R6: `in_ready` is high only while idle. Operands presented while `in_ready` is low are not taken. They change neither the pending result nor its latency, and they start no further operation.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_result` stays stable. The edge on which both are high returns the block to idle, so `in_ready` is high and `out_valid` is low afterwards.
- R8: After a synchronous reset, `in_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on the input are valid |
| in_ready | output | 1 | Block is idle and takes operands on this edge |
| in_dividend | input | 64 | Unsigned dividend |
| in_divisor | input | 64 | Unsigned divisor |
| in_modulo | input | 1 | 1 returns the remainder, 0 the quotient |
| in_narrow | input | 1 | 1 divides the lower 32 bits only |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_result | output | 64 | Quotient or remainder |

## Verification
A reciprocal that is refined too little, or a seed table entry that is wrong, shows at the ports as a quotient that is two or more below the true one. The same fault gives a remainder that is not below the divisor. Either error appears on the same `out_valid` that ends the operation, at most eleven edges after acceptance. Operands with large quotients, such as a divisor of 1 or 3 with an all-ones dividend, expose precision loss first. A step counter or state sequence that goes wrong moves `out_valid` away from its computed edge, so the latency check catches it within one operation. A lost handshake shows as `in_ready` and `out_valid` high together, or as a result that changes while it is held.

// File: rtl/dv_pkg.sv
`timescale 1ns/1ps
package dv_pkg;

  // Sequencer states of the divider
  typedef enum logic [3:0] {
    S_IDLE,
    S_SEED,
    S_NR_MUL,
    S_NR_UPD,
    S_FIX,
    S_QEST,
    S_REM,
    S_CORR,
    S_DONE
  } dv_state_e;

endpackage

// File: rtl/dv_lead_one.sv
`timescale 1ns/1ps
// Position of the most significant set bit (0 when the input is zero)
module dv_lead_one #(
  parameter int W  = 64,
  parameter int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos
);

  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) pos = PW'(i);
    end
  end

endmodule

// File: rtl/dv_seed_rom.sv
`timescale 1ns/1ps
// Coarse reciprocal of a normalised divisor in [1,2).
// Entry i approximates 1/(1 + (i+0.5)/2^IDX_W), rounded to SEED_FRAC bits.
module dv_seed_rom #(
  parameter int IDX_W     = 8,
  parameter int SEED_FRAC = 12
) (
  input  logic [IDX_W-1:0]   idx,
  output logic [SEED_FRAC:0] seed
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int SW      = SEED_FRAC + 1;

  logic [SW-1:0] tab [ENTRIES];

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_ent
    localparam longint unsigned NUMER = 64'd1 << (SEED_FRAC + IDX_W + 2);
    localparam longint unsigned DENOM = (64'd1 << (IDX_W + 1)) + 64'd1 + 64'(2 * gi);
    localparam longint unsigned VAL   = ((NUMER / DENOM) + 64'd1) >> 1;
    assign tab[gi] = SW'(VAL);
  end

  assign seed = tab[idx];

endmodule

// File: rtl/dv_mul.sv
`timescale 1ns/1ps
// Shared unsigned multiplier, full-width product
module dv_mul #(
  parameter int AW = 74,
  parameter int BW = 74
) (
  input  logic [AW-1:0]    a,
  input  logic [BW-1:0]    b,
  output logic [AW+BW-1:0] p
);

  assign p = {{BW{1'b0}}, a} * {{AW{1'b0}}, b};

endmodule

// File: rtl/recip_divider.sv
`timescale 1ns/1ps
module recip_divider #(
  parameter int DATA_W     = 64,
  parameter int RECIP_FRAC = DATA_W + 8,
  parameter int IDX_W      = 8,
  parameter int SEED_FRAC  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_dividend,
  input  logic [DATA_W-1:0] in_divisor,
  input  logic              in_modulo,
  input  logic              in_narrow,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result
);
  import dv_pkg::*;

  localparam int KW         = $clog2(DATA_W);
  localparam int HALF_W     = DATA_W / 2;
  localparam int ITER1_BITS = DATA_W / 4;
  localparam int ITER2_BITS = DATA_W / 2;
  localparam int YW         = RECIP_FRAC + 1;   // reciprocal, 1 integer bit
  localparam int TW         = RECIP_FRAC + 2;   // d*y and 2-d*y, 2 integer bits
  localparam int MW         = TW;               // multiplier operand width
  localparam int PW         = 2 * MW;
  localparam int SW         = SEED_FRAC + 1;

  localparam logic [DATA_W-1:0] HALF_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  localparam logic [TW-1:0]     TWO_FX    = {2'b10, {RECIP_FRAC{1'b0}}};
  localparam logic [YW-1:0]     HALF_FX   = {2'b01, {(RECIP_FRAC-1){1'b0}}};

  dv_state_e st;

  logic [DATA_W-1:0] num_q, den_q, dn_q, quo_q, rem_q, res_q;
  logic [KW-1:0]     k_q;
  logic [1:0]        iter_q;
  logic              mod_q;
  logic [YW-1:0]     y_q;
  logic [TW-1:0]     t_q;

  // ---------------- input conditioning ----------------
  logic [DATA_W-1:0] n_in, d_in, dn_in;
  logic [KW-1:0]     k_in;
  logic [1:0]        iters_in;

  assign n_in = in_narrow ? (in_dividend & HALF_MASK) : in_dividend;
  assign d_in = in_narrow ? (in_divisor  & HALF_MASK) : in_divisor;

  dv_lead_one #(.W(DATA_W), .PW(KW)) u_lead (
    .vec (d_in),
    .pos (k_in)
  );

  assign dn_in = d_in << (KW'(DATA_W - 1) - k_in);

  always_comb begin
    if ((n_in >> ITER1_BITS) == '0)      iters_in = 2'd1;
    else if ((n_in >> ITER2_BITS) == '0) iters_in = 2'd2;
    else                                 iters_in = 2'd3;
  end

  // ---------------- reciprocal seed ----------------
  logic [SW-1:0] seed;
  logic [YW-1:0] y_seed;

  dv_seed_rom #(.IDX_W(IDX_W), .SEED_FRAC(SEED_FRAC)) u_seed (
    .idx  (dn_q[DATA_W-2 -: IDX_W]),
    .seed (seed)
  );

  assign y_seed = {seed, {(RECIP_FRAC-SEED_FRAC){1'b0}}};

  // ---------------- shared multiplier ----------------
  logic [MW-1:0] mul_a, mul_b;
  logic [PW-1:0] prod;
  logic [TW-1:0] two_minus;

  assign two_minus = TWO_FX - t_q;

  always_comb begin
    mul_a = '0;
    mul_b = '0;
    unique case (st)
      S_NR_MUL: begin mul_a = MW'(dn_q);  mul_b = MW'(y_q);  end
      S_NR_UPD: begin mul_a = MW'(y_q);   mul_b = two_minus; end
      S_QEST:   begin mul_a = MW'(num_q); mul_b = MW'(y_q);  end
      S_REM:    begin mul_a = MW'(quo_q); mul_b = MW'(den_q); end
      default:  begin mul_a = '0;         mul_b = '0;        end
    endcase
  end

  dv_mul #(.AW(MW), .BW(MW)) u_mul (
    .a (mul_a),
    .b (mul_b),
    .p (prod)
  );

  // ---------------- datapath results ----------------
  logic [TW-1:0]     t_next;
  logic [YW-1:0]     y_upd, y_dec, y_fixed;
  logic [DATA_W:0]   q_wide;
  logic [DATA_W-1:0] rem_next;

  assign t_next   = prod[DATA_W-1 +: TW];
  assign y_upd    = prod[RECIP_FRAC +: YW];
  assign y_dec    = y_q - YW'(2);
  assign y_fixed  = (y_dec[RECIP_FRAC -: 2] == 2'b00) ? HALF_FX : y_dec;
  assign q_wide   = prod[RECIP_FRAC +: DATA_W+1] >> k_q;
  assign rem_next = num_q - prod[DATA_W-1:0];

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      num_q  <= '0;
      den_q  <= '0;
      dn_q   <= '0;
      k_q    <= '0;
      iter_q <= '0;
      mod_q  <= 1'b0;
      y_q    <= '0;
      t_q    <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      res_q  <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (in_valid) begin
            num_q  <= n_in;
            den_q  <= d_in;
            dn_q   <= dn_in;
            k_q    <= k_in;
            iter_q <= iters_in;
            mod_q  <= in_modulo;
            if (d_in == '0) begin
              res_q <= '0;
              st    <= S_DONE;
            end else begin
              st <= S_SEED;
            end
          end
        end
        S_SEED: begin
          y_q <= y_seed;
          st  <= S_NR_MUL;
        end
        S_NR_MUL: begin
          t_q <= t_next;
          st  <= S_NR_UPD;
        end
        S_NR_UPD: begin
          y_q    <= y_upd;
          iter_q <= iter_q - 2'd1;
          st     <= (iter_q == 2'd1) ? S_FIX : S_NR_MUL;
        end
        S_FIX: begin
          y_q <= y_fixed;
          st  <= S_QEST;
        end
        S_QEST: begin
          quo_q <= q_wide[DATA_W-1:0];
          st    <= S_REM;
        end
        S_REM: begin
          rem_q <= rem_next;
          st    <= S_CORR;
        end
        S_CORR: begin
          if (rem_q >= den_q) res_q <= mod_q ? (rem_q - den_q) : (quo_q + DATA_W'(1));
          else                res_q <= mod_q ? rem_q : quo_q;
          st <= S_DONE;
        end
        S_DONE: begin
          if (out_ready) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign in_ready   = (st == S_IDLE);
  assign out_valid  = (st == S_DONE);
  assign out_result = res_q;

endmodule

// File: rtl/recip_divider_chk.sv
`timescale 1ns/1ps
module recip_divider_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_divisor,
  input logic              in_modulo,
  input logic              in_narrow,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result
);

  localparam int HALF_W = DATA_W / 2;

  logic              c_mod, c_nar;
  logic [DATA_W-1:0] c_den;
  logic              zero_div;

  assign zero_div = in_narrow ? (in_divisor[HALF_W-1:0] == '0) : (in_divisor == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      c_mod <= 1'b0;
      c_nar <= 1'b0;
      c_den <= '0;
    end else if (in_valid && in_ready) begin
      c_mod <= in_modulo;
      c_nar <= in_narrow;
      c_den <= in_narrow ? {{(DATA_W-HALF_W){1'b0}}, in_divisor[HALF_W-1:0]} : in_divisor;
    end
  end

  a_r8_reset_idle: assert property (@(posedge clk) rst |=> (in_ready && !out_valid));

  a_r6_not_both: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  a_r6_busy_stays: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !out_valid) |=> !in_ready);

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (in_ready && !out_valid));

  a_r4_zero_div: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && zero_div) |=> (out_valid && out_result == '0));

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && c_nar) |-> (out_result[DATA_W-1:HALF_W] == '0));

  a_r2_rem_below: assert property (@(posedge clk) disable iff (rst)
    (out_valid && c_mod && c_den != '0) |-> (out_result < c_den));

endmodule

bind recip_divider recip_divider_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_divisor (in_divisor),
  .in_modulo  (in_modulo),
  .in_narrow  (in_narrow),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result)
);

// File: tb/recip_divider_bench.sv
`timescale 1ns/1ps
module recip_divider_bench;

  localparam int DW = 64;
  localparam int NV = 19;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  // stimulus and expected latency vectors
  localparam logic [63:0] TN [NV] = '{
    64'd100, 64'd100, ONES, ONES, ONES,
    64'h8000_0000_0000_0000, 64'd12345, 64'd12345, 64'd65536, 64'h0000_0000_FFFF_FFFF,
    64'h0000_0001_0000_0000, 64'hDEAD_BEEF_0000_1000, ONES, 64'd555, 64'd777,
    64'd0, 64'hFEDC_BA98_7654_3210, 64'hFEDC_BA98_7654_3210, ONES};
  localparam logic [63:0] TD [NV] = '{
    64'd7, 64'd7, 64'd1, ONES, 64'd3,
    64'h0000_0001_0000_0000, ONES, ONES, 64'd3, 64'd10,
    64'd16, 64'h1234_0000_0000_0010, 64'h0000_0000_0001_0000, 64'd0, 64'hFFFF_FFFF_0000_0000,
    64'd5, 64'd3, 64'h0000_0123_4567_89AB, 64'h8000_0000_0000_0000};
  localparam bit TM [NV] = '{0,1,0,0,1, 0,0,1,0,0, 0,0,1,0,0, 0,0,1,1};
  localparam bit TW [NV] = '{0,0,0,0,0, 0,0,0,0,0, 0,1,1,0,1, 0,0,0,0};
  localparam int TL [NV] = '{7,7,11,11,11, 11,7,7,9,9, 11,7,9,1,1, 7,11,11,11};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_dividend = '0;
  logic [DW-1:0] in_divisor = '0;
  logic in_modulo = 1'b0;
  logic in_narrow = 1'b0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [DW-1:0] out_result;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  recip_divider u_recip_divider (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_dividend (in_dividend),
    .in_divisor  (in_divisor),
    .in_modulo   (in_modulo),
    .in_narrow   (in_narrow),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_result  (out_result)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !finished) begin
      errors = errors + 1;
      $display("FAIL R5 watchdog: actual %0d cycles expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [63:0] mask_op(input logic [63:0] v, input bit nar);
    return nar ? {32'h0, v[31:0]} : v;
  endfunction

  function automatic logic [63:0] model_res(input logic [63:0] n, d, input bit m, nar);
    logic [63:0] nn, dd;
    nn = mask_op(n, nar);
    dd = mask_op(d, nar);
    if (dd == 0) return 64'd0;
    return m ? (nn % dd) : (nn / dd);
  endfunction

  function automatic int model_lat(input logic [63:0] n, d, input bit nar);
    logic [63:0] nn, dd;
    int it;
    nn = mask_op(n, nar);
    dd = mask_op(d, nar);
    if (dd == 0) return 1;
    if (nn < 64'h1_0000) it = 1;
    else if (nn < 64'h1_0000_0000) it = 2;
    else it = 3;
    return 5 + 2 * it;
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // issue one operation, return result and edges from acceptance to out_valid
  task automatic do_op(input logic [63:0] n, d, input bit m, nar,
                       output logic [63:0] res, output int lat);
    @(negedge clk);
    in_dividend = n;
    in_divisor  = d;
    in_modulo   = m;
    in_narrow   = nar;
    in_valid    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    res = '0;
    while (lat < 64) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (out_valid) break;
    end
    res = out_result;
  endtask

  task automatic release_out();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    logic [63:0] res, res0, n, d;
    int lat;
    bit m, nar;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check64("R8 in_ready after reset", {63'd0, in_ready}, 64'd1);
    check64("R8 out_valid after reset", {63'd0, out_valid}, 64'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      do_op(TN[i], TD[i], TM[i], TW[i], res, lat);
      check64(TM[i] ? "R2 remainder (table)" : "R1 quotient (table)",
              res, model_res(TN[i], TD[i], TM[i], TW[i]));
      check_int("R5 latency (table)", lat, TL[i]);
      if (TW[i]) check64("R3 upper half zero", {32'h0, res[63:32]}, 64'd0);
      if (mask_op(TD[i], TW[i]) == 0) check64("R4 zero divisor result", res, 64'd0);
      release_out();
      check64("R7 idle after handshake", {62'd0, in_ready, out_valid}, 64'd2);
    end

    // random operands of varied magnitude
    for (int i = 0; i < 60; i++) begin
      n   = {$urandom(), $urandom()} >> ($urandom() % 64);
      d   = {$urandom(), $urandom()} >> ($urandom() % 64);
      m   = bit'($urandom() % 2);
      nar = (($urandom() % 4) == 0);
      do_op(n, d, m, nar, res, lat);
      check64(m ? "R2 remainder (random)" : "R1 quotient (random)", res, model_res(n, d, m, nar));
      check_int("R5 latency (random)", lat, model_lat(n, d, nar));
      release_out();
    end

    // R7: result held under back-pressure
    do_op(64'd1000, 64'd7, 1'b0, 1'b0, res0, lat);
    check64("R1 quotient before hold", res0, 64'd142);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check64("R7 out_valid held", {63'd0, out_valid}, 64'd1);
      check64("R7 result stable", out_result, res0);
    end
    release_out();
    check64("R7 in_ready after release", {63'd0, in_ready}, 64'd1);
    check64("R7 out_valid after release", {63'd0, out_valid}, 64'd0);

    // R6: operands offered while busy are ignored
    @(negedge clk);
    in_dividend = 64'd50000;
    in_divisor  = 64'd9;
    in_modulo   = 1'b0;
    in_narrow   = 1'b0;
    in_valid    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_dividend = 64'd7;
    in_divisor  = 64'd1;
    in_modulo   = 1'b1;
    lat = 0;
    check64("R6 in_ready low while busy", {63'd0, in_ready}, 64'd0);
    while (lat < 64) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (out_valid) break;
    end
    in_valid = 1'b0;
    check64("R6 result unaffected by ignored operands", out_result, 64'd5555);
    check_int("R6 latency unaffected by ignored operands", lat, 7);
    release_out();
    @(negedge clk);
    check64("R6 no second operation started", {62'd0, in_ready, out_valid}, 64'd2);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule